// File: doc/BRIEF.md
# Memory ECC Error Reporting Unit

This block gathers the error events of a memory controller and turns them into readable status and one interrupt line to the processor. For every returned read, an ECC checker reports whether it corrected a single-bit fault or found an uncorrectable multi-bit fault. For every access, the upper address bits are compared against a set of chip-select ranges.

Uncorrectable faults are reported at once. Correctable faults are only counted, and they become visible when the count reaches a programmable threshold. A further correctable fault after that point raises a separate repeat flag. An access whose address falls inside no enabled chip-select range raises its own flag. The first error seen from a clean status captures the faulting address and the error kind.

Software reads and clears the status through a simple register bus. Status bits are write-1-to-clear. It sets the interrupt mask, the threshold and the chip-select ranges through the same bus.

Top module: `memerr_report`

## Requirements
- R1: A read access (`acc_valid`=1, `acc_write`=0) with `ecc_mbe`=1 sets status bit 0 (uncorrectable) on the next clock edge.
- R2: A write access never changes the correctable-error count or the ECC status bits (0, 1, 2), whatever `ecc_sbe`/`ecc_mbe` show.
- R3: Each read with `ecc_sbe`=1 raises the count (register 2, bits 16 and up) by one. No status bit is set while the new count is below the threshold (register 2, bits CNT_W-1:0).
- R4: A correctable read that brings the count to the threshold or above sets status bit 1.
- R5: A correctable read while status bit 1 is already set sets status bit 2 (repeat error).
- R6: Any access whose top CMP_W address bits lie in no enabled chip-select range sets status bit 3. Ranges are inclusive at both ends. Chip-select register 8+i holds the start in bits CMP_W-1:0, the end in bits 2*CMP_W-1:CMP_W and the enable in bit 31.
- R7: Writing 1 to a status bit (register 0) clears it, and writing 0 leaves it unchanged. Clearing bit 1 also sets the count to zero.
- R8: The count stops at 2^CNT_W-1 and does not wrap.
- R9: A threshold of zero never sets status bit 1, but the count still advances.
- R10: An error that sets status while all status bits are clear captures the access address (register 3) and the newly set bits (register 4). Later errors leave the capture unchanged until status is fully cleared.
- R11: When `ecc_mbe` and `ecc_sbe` arrive on the same read, only bit 0 is set and the count does not change.
- R12: `irq` equals the OR of (status AND interrupt enable, register 1), one cycle after the status changes.
- R13: After reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access is a write (1) or a returned read (0) |
| acc_addr | input | ADDR_W | Access address |
| ecc_sbe | input | 1 | Checker corrected a single-bit fault |
| ecc_mbe | input | 1 | Checker found an uncorrectable fault |
| reg_en | input | 1 | Register bus select |
| reg_wr | input | 1 | Register bus write |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with a 4-bit counter and an 8-bit chip-select compare. This lets saturation at 15 be reached in a few dozen reads, and keeps the range bounds small enough to probe each edge by hand. Four ranges are programmed with one left disabled, so the tests cover inclusive ends, single-value ranges and disabled ranges. A threshold of 3 lets one short run of correctable reads cross the counting, reporting and repeat stages in turn.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
    localparam int ST_W  = 4;
    localparam int MBE_B = 0;
    localparam int SBE_B = 1;
    localparam int MME_B = 2;
    localparam int MSE_B = 3;

    localparam logic [3:0] RA_STATUS  = 4'd0;
    localparam logic [3:0] RA_INTEN   = 4'd1;
    localparam logic [3:0] RA_SBCTL   = 4'd2;
    localparam logic [3:0] RA_CAPADDR = 4'd3;
    localparam logic [3:0] RA_CAPTYPE = 4'd4;
    localparam int         RA_CSBASE  = 8;

    typedef logic [ST_W-1:0] stat_t;
endpackage

// File: rtl/memerr_csmatch.sv
module memerr_csmatch #(
    parameter int NUM_CS = 4,
    parameter int CMP_W  = 8
) (
    input  logic [NUM_CS*CMP_W-1:0] lo_flat,
    input  logic [NUM_CS*CMP_W-1:0] hi_flat,
    input  logic [NUM_CS-1:0]       en,
    input  logic [CMP_W-1:0]        key,
    output logic                    hit
);
    logic [NUM_CS-1:0] inr;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign inr[i] = en[i]
                      && (key >= lo_flat[i*CMP_W +: CMP_W])
                      && (key <= hi_flat[i*CMP_W +: CMP_W]);
    end

    assign hit = |inr;
endmodule

// File: rtl/memerr_satinc.sv
module memerr_satinc #(
    parameter int W = 8
) (
    input  logic [W-1:0] base,
    input  logic         inc,
    input  logic [W-1:0] thresh,
    output logic [W-1:0] nxt,
    output logic         reached
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        nxt     = (inc && base != TOP) ? base + 1'b1 : base;
        reached = inc && (thresh != '0) && (nxt >= thresh);
    end
endmodule

// File: rtl/memerr_report.sv
module memerr_report
    import memerr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_CS = 4,
    parameter int CMP_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              ecc_sbe,
    input  logic              ecc_mbe,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int CS_BITS = NUM_CS * CMP_W;
    localparam int CNT_LSB = 16;

    typedef struct packed {
        stat_t              status;
        stat_t              inten;
        logic [CNT_W-1:0]   thresh;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  cap_addr;
        stat_t              cap_type;
        logic [NUM_CS-1:0]  cs_en;
        logic [CS_BITS-1:0] cs_lo;
        logic [CS_BITS-1:0] cs_hi;
        logic               irq;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             bus_wr, rd_acc, cs_hit;
    logic             mbe_ev, sbe_ev, sbe_reach;
    stat_t            clr_mask, set_v, status_base;
    logic [CNT_W-1:0] cnt_base, cnt_next;

    assign bus_wr   = reg_en && reg_wr;
    assign rd_acc   = acc_valid && !acc_write;
    assign mbe_ev   = rd_acc && ecc_mbe;
    assign sbe_ev   = rd_acc && ecc_sbe && !ecc_mbe;
    assign clr_mask = (bus_wr && reg_addr == RA_STATUS) ? reg_wdata[ST_W-1:0] : '0;
    assign cnt_base = clr_mask[SBE_B] ? '0 : regs_q.cnt;

    memerr_csmatch #(.NUM_CS(NUM_CS), .CMP_W(CMP_W)) u_csm (
        .lo_flat (regs_q.cs_lo),
        .hi_flat (regs_q.cs_hi),
        .en      (regs_q.cs_en),
        .key     (acc_addr[ADDR_W-1 -: CMP_W]),
        .hit     (cs_hit)
    );

    memerr_satinc #(.W(CNT_W)) u_cnt (
        .base    (cnt_base),
        .inc     (sbe_ev),
        .thresh  (regs_q.thresh),
        .nxt     (cnt_next),
        .reached (sbe_reach)
    );

    always_comb begin
        regs_d      = regs_q;
        status_base = regs_q.status & ~clr_mask;

        set_v        = '0;
        set_v[MBE_B] = mbe_ev;
        set_v[SBE_B] = sbe_reach;
        set_v[MME_B] = sbe_ev && status_base[SBE_B];
        set_v[MSE_B] = acc_valid && !cs_hit;

        regs_d.status = status_base | set_v;
        regs_d.cnt    = cnt_next;

        if (status_base == '0 && set_v != '0) begin
            regs_d.cap_addr = acc_addr;
            regs_d.cap_type = set_v;
        end

        if (bus_wr) begin
            if (reg_addr == RA_INTEN) regs_d.inten  = reg_wdata[ST_W-1:0];
            if (reg_addr == RA_SBCTL) regs_d.thresh = reg_wdata[CNT_W-1:0];
            for (int i = 0; i < NUM_CS; i++) begin
                if (int'(reg_addr) == RA_CSBASE + i) begin
                    regs_d.cs_lo[i*CMP_W +: CMP_W] = reg_wdata[CMP_W-1:0];
                    regs_d.cs_hi[i*CMP_W +: CMP_W] = reg_wdata[CMP_W +: CMP_W];
                    regs_d.cs_en[i]                = reg_wdata[31];
                end
            end
        end

        regs_d.irq = |(regs_q.status & regs_q.inten);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_STATUS:  reg_rdata[ST_W-1:0] = regs_q.status;
            RA_INTEN:   reg_rdata[ST_W-1:0] = regs_q.inten;
            RA_SBCTL: begin
                reg_rdata[CNT_W-1:0]           = regs_q.thresh;
                reg_rdata[CNT_LSB +: CNT_W]    = regs_q.cnt;
            end
            RA_CAPADDR: reg_rdata[ADDR_W-1:0] = regs_q.cap_addr;
            RA_CAPTYPE: reg_rdata[ST_W-1:0]   = regs_q.cap_type;
            default: begin
                for (int i = 0; i < NUM_CS; i++) begin
                    if (int'(reg_addr) == RA_CSBASE + i) begin
                        reg_rdata[CMP_W-1:0]     = regs_q.cs_lo[i*CMP_W +: CMP_W];
                        reg_rdata[CMP_W +: CMP_W] = regs_q.cs_hi[i*CMP_W +: CMP_W];
                        reg_rdata[31]             = regs_q.cs_en[i];
                    end
                end
            end
        endcase
    end

    assign irq = regs_q.irq;
endmodule

// File: rtl/memerr_report_chk.sv
module memerr_report_chk
    import memerr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             ecc_sbe,
    input logic             ecc_mbe,
    input logic             bus_wr,
    input stat_t            status,
    input stat_t            inten,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thresh,
    input logic             irq
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_mbe_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && ecc_mbe |=> status[MBE_B]);

    p_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && !bus_wr |=> $stable(cnt));

    p_mme_after_sbe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[MME_B]) |-> $past(status[SBE_B]));

    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP) && !bus_wr |=> (cnt == TOP));

    p_thresh0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0) && !status[SBE_B] && !bus_wr |=> !status[SBE_B]);

    p_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && ecc_mbe && ecc_sbe && !bus_wr |=> $stable(cnt));

    p_irq_lag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & inten))));
endmodule

bind memerr_report memerr_report_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .ecc_sbe   (ecc_sbe),
    .ecc_mbe   (ecc_mbe),
    .bus_wr    (reg_en && reg_wr),
    .status    (regs_q.status),
    .inten     (regs_q.inten),
    .cnt       (regs_q.cnt),
    .thresh    (regs_q.thresh),
    .irq       (irq)
);

// File: tb/sim_memerr_report.sv
`timescale 1ns/1ps
module sim_memerr_report;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0, acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              ecc_sbe = 1'b0, ecc_mbe = 1'b0;
    logic              reg_en = 1'b0, reg_wr = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    memerr_report #(.ADDR_W(ADDR_W), .NUM_CS(4), .CMP_W(8), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .ecc_sbe(ecc_sbe), .ecc_mbe(ecc_mbe),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic access(input logic w, input logic [31:0] a, input logic s, input logic m);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; ecc_sbe = s; ecc_mbe = m;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; ecc_sbe = 1'b0; ecc_mbe = 1'b0;
    endtask

    function automatic logic [31:0] cs_word(input logic [7:0] lo, input logic [7:0] hi, input logic e);
        return {e, 15'd0, hi, lo};
    endfunction

    function automatic logic [31:0] sbctl(input int th, input int c);
        return (32'(c) << 16) | 32'(th);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 12; a++) begin
            rd_reg(4'(a), v);
            chk("R13 reset register", v, 32'h0);
        end
        chk("R13 reset irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_setup();
        wr_reg(4'd8,  cs_word(8'h10, 8'h1F, 1'b1));
        wr_reg(4'd9,  cs_word(8'h40, 8'h40, 1'b1));
        wr_reg(4'd10, cs_word(8'h80, 8'hFF, 1'b0));
        wr_reg(4'd11, cs_word(8'h20, 8'h2F, 1'b1));
        wr_reg(4'd2,  32'd3);
    endtask

    task automatic t_mbe();
        logic [31:0] v;
        access(1'b0, 32'h1000_0040, 1'b0, 1'b1);
        rd_reg(4'd0, v); chk("R1 mbe status", v, 32'h1);
        rd_reg(4'd3, v); chk("R10 capture addr mbe", v, 32'h1000_0040);
        rd_reg(4'd4, v); chk("R10 capture type mbe", v, 32'h1);
        wr_reg(4'd0, 32'hF);
        rd_reg(4'd0, v); chk("R7 status cleared", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr_reg(4'd1, 32'h1);
        access(1'b0, 32'h1000_0000, 1'b0, 1'b1);
        chk("R12 irq not yet", {31'd0, irq}, 32'h0);
        @(negedge clk);
        chk("R12 irq raised", {31'd0, irq}, 32'h1);
        wr_reg(4'd0, 32'h1);
        chk("R12 irq lags clear", {31'd0, irq}, 32'h1);
        @(negedge clk);
        chk("R12 irq dropped", {31'd0, irq}, 32'h0);
        access(1'b0, 32'h3000_0000, 1'b0, 1'b0);
        @(negedge clk);
        chk("R12 masked bit no irq", {31'd0, irq}, 32'h0);
        rd_reg(4'd0, v); chk("R6 masked mse status", v, 32'h8);
        wr_reg(4'd0, 32'hF);
        wr_reg(4'd1, 32'h0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        access(1'b1, 32'h1000_0000, 1'b1, 1'b1);
        access(1'b1, 32'h1000_0000, 1'b1, 1'b0);
        rd_reg(4'd0, v); chk("R2 write status", v, 32'h0);
        rd_reg(4'd2, v); chk("R2 write count", v, sbctl(3, 0));
    endtask

    task automatic t_sbe();
        logic [31:0] v;
        access(1'b0, 32'h1000_0100, 1'b1, 1'b0);
        access(1'b0, 32'h1000_0200, 1'b1, 1'b0);
        rd_reg(4'd0, v); chk("R3 below threshold status", v, 32'h0);
        rd_reg(4'd2, v); chk("R3 count two", v, sbctl(3, 2));
        access(1'b0, 32'h1000_0300, 1'b1, 1'b0);
        rd_reg(4'd0, v); chk("R4 threshold reached", v, 32'h2);
        access(1'b0, 32'h1000_0400, 1'b1, 1'b0);
        rd_reg(4'd0, v); chk("R5 repeat flag", v, 32'h6);
        rd_reg(4'd2, v); chk("R3 count four", v, sbctl(3, 4));
        rd_reg(4'd3, v); chk("R10 capture kept", v, 32'h1000_0300);
        rd_reg(4'd4, v); chk("R10 capture type sbe", v, 32'h2);
        wr_reg(4'd0, 32'h2);
        rd_reg(4'd0, v); chk("R7 partial clear", v, 32'h4);
        rd_reg(4'd2, v); chk("R7 count reset", v, sbctl(3, 0));
        wr_reg(4'd0, 32'h4);
        rd_reg(4'd0, v); chk("R7 clear repeat", v, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        access(1'b0, 32'h2000_0000, 1'b1, 1'b1);
        rd_reg(4'd0, v); chk("R11 only mbe", v, 32'h1);
        rd_reg(4'd2, v); chk("R11 count unchanged", v, sbctl(3, 0));
        wr_reg(4'd0, 32'hF);
    endtask

    task automatic t_mse();
        logic [31:0] v;
        logic [31:0] hits [4]   = '{32'h1000_0000, 32'h1FFF_FFFF, 32'h40AB_0000, 32'h2F00_0001};
        logic [31:0] misses [4] = '{32'h0FFF_FFFF, 32'h3000_0000, 32'h8000_0000, 32'h4100_0000};
        foreach (hits[i]) begin
            access(1'b0, hits[i], 1'b0, 1'b0);
            rd_reg(4'd0, v); chk("R6 in-range no error", v, 32'h0);
        end
        foreach (misses[i]) begin
            access(1'b1, misses[i], 1'b0, 1'b0);
            rd_reg(4'd0, v); chk("R6 out-of-range error", v, 32'h8);
            rd_reg(4'd3, v); chk("R10 capture mse addr", v, misses[i]);
            wr_reg(4'd0, 32'h8);
        end
    endtask

    task automatic t_thresh0();
        logic [31:0] v;
        wr_reg(4'd2, 32'd0);
        for (int k = 0; k < 5; k++) access(1'b0, 32'h1000_0000, 1'b1, 1'b0);
        rd_reg(4'd0, v); chk("R9 no sbe at zero threshold", v, 32'h0);
        rd_reg(4'd2, v); chk("R9 count advances", v, sbctl(0, 5));
    endtask

    task automatic t_sat();
        logic [31:0] v;
        for (int k = 0; k < 20; k++) access(1'b0, 32'h1000_0000, 1'b1, 1'b0);
        rd_reg(4'd2, v); chk("R8 count saturates", v, sbctl(0, 15));
        rd_reg(4'd0, v); chk("R9 still silent", v, 32'h0);
        wr_reg(4'd0, 32'h2);
        rd_reg(4'd2, v); chk("R7 clear resets saturated count", v, sbctl(0, 0));
    endtask

    task automatic t_capture();
        logic [31:0] v;
        access(1'b0, 32'h5500_0000, 1'b0, 1'b0);
        access(1'b0, 32'h1234_5678, 1'b0, 1'b1);
        rd_reg(4'd0, v); chk("R10 both bits", v, 32'h9);
        rd_reg(4'd3, v); chk("R10 first addr held", v, 32'h5500_0000);
        rd_reg(4'd4, v); chk("R10 first type held", v, 32'h8);
        wr_reg(4'd0, 32'hF);
        access(1'b0, 32'h1234_5678, 1'b0, 1'b1);
        rd_reg(4'd3, v); chk("R10 recapture after clear", v, 32'h1234_5678);
        wr_reg(4'd0, 32'hF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_mbe();
        t_irq();
        t_write();
        t_sbe();
        t_prio();
        t_mse();
        t_thresh0();
        t_sat();
        t_capture();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule